// File: doc/BRIEF.md
# Sync Output Polarity Controller

This block takes one raw sync signal, horizontal or vertical, and drives a conditioned copy of it with a polarity set by two control inputs. In pass-through mode the copy is either the input unchanged or its inverse. In auto mode the block first measures the input's polarity. It counts the clocks the synchronised input spends high and low between successive rising edges and takes the shorter phase as the sync pulse. It then drives a fixed polarity: active low when the invert control is 0, active high when it is 1. This holds whichever polarity the input has.

The raw input first passes through a synchroniser chain (`spc_sync`). The polarity detector (`spc_pol_detect`) is a three-state machine. `ST_HUNT` waits for the first rising edge after reset. `ST_HIGH` counts the high phase and leaves on a falling edge (transition HIGH_TO_LOW). `ST_LOW` counts the low phase. A rising edge in `ST_LOW` takes the COMMIT transition back to `ST_HIGH` and stores the new polarity flag. The first rising edge seen in `ST_HUNT` takes the START transition to `ST_HIGH` and commits nothing.

The output stage (`spc_out_stage`) holds a mode register with four states, set from the two controls and reset to `MODE_PASS`:
- `MODE_PASS`: auto 0, invert 0.
- `MODE_INV`: auto 0, invert 1.
- `MODE_NEG`: auto 1, invert 0.
- `MODE_POS`: auto 1, invert 1.

A registered output follows the mode register.

Top module: `sync_pol_ctrl`

## Requirements
- R1: With auto_en=0 and inv_sel=0, sync_out equals sync_in with the same polarity.
- R2: With auto_en=0 and inv_sel=1, sync_out is the logical inverse of sync_in.
- R3: With auto_en=1 and inv_sel=0, sync_out is a negative-polarity sync (pulse low, idle high): it equals the synchronised input when pol_pos=0 and its inverse when pol_pos=1.
- R4: With auto_en=1 and inv_sel=1, sync_out is a positive-polarity sync (pulse high, idle low): it equals the inverse of the synchronised input when pol_pos=0 and the input itself when pol_pos=1.
- R5: While rst is high and at the first clock after it falls, sync_out=0 and pol_pos=0, and the mode register is `MODE_PASS`. With the controls held at auto mode through reset, the first output after release is still computed in pass mode, and the auto mode first applies to the second output after release.
- R6: pol_pos is 1 (positive input) exactly when the count of high clocks in the last complete period is strictly smaller than the count of low clocks. Equal counts give pol_pos=0 (negative).
- R7: pol_pos changes only when a rising edge completes a full high-then-low period. It stays 0 from reset until the second rising edge of the synchronised input.
- R8: The latency from sync_in to sync_out is three clocks: two synchroniser flops plus the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sync_in | input | 1 | Raw sync input, asynchronous to clk |
| auto_en | input | 1 | 1 selects auto-polarity mode |
| inv_sel | input | 1 | Pass mode: 1 inverts the input; auto mode: 1 requests positive output |
| sync_out | output | 1 | Conditioned sync output |
| pol_pos | output | 1 | Detected input polarity, 1 = positive (high pulse) |

## Verification
The bench drives sync_in just after a falling clock edge. It checks sync_out at the third falling edge after a drive against the value driven three edges earlier, which covers two synchroniser flops and the output register. A new pol_pos appears at the third rising edge after the rising input edge that completes a period. The bench therefore checks pol_pos at falling edges two and three after that drive, expecting the old value and then the new one. After any change of control bits or waveform, output checks wait for two full periods. This lets both the mode register (one clock) and the detector's first commit settle before any comparison is made.

// File: rtl/spc_pkg.sv
package spc_pkg;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } det_state_e;

    typedef enum logic [1:0] {
        MODE_PASS = 2'd0,
        MODE_INV  = 2'd1,
        MODE_NEG  = 2'd2,
        MODE_POS  = 2'd3
    } out_mode_e;

endpackage

// File: rtl/spc_sync.sv
module spc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[LAST-1:0], d};
            end
        end
    endgenerate

    assign q = chain_q[LAST];

endmodule

// File: rtl/spc_pol_detect.sv
module spc_pol_detect
    import spc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic sync_s,
    output logic pol_pos
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    det_state_e       state_q, state_d;
    logic [CNT_W-1:0] hi_cnt_q, hi_cnt_d;
    logic [CNT_W-1:0] lo_cnt_q, lo_cnt_d;
    logic             prev_q;
    logic             commit;
    logic             pol_pos_q;

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] c);
        return (c == CNT_MAX) ? c : c + CNT_ONE;
    endfunction

    // next-state and counter logic
    always_comb begin
        state_d  = state_q;
        hi_cnt_d = hi_cnt_q;
        lo_cnt_d = lo_cnt_q;
        commit   = 1'b0;
        unique case (state_q)
            ST_HUNT: begin
                if (sync_s && !prev_q) begin      // START
                    state_d  = ST_HIGH;
                    hi_cnt_d = CNT_ONE;
                    lo_cnt_d = '0;
                end
            end
            ST_HIGH: begin
                if (sync_s) begin
                    hi_cnt_d = sat_inc(hi_cnt_q);
                end else begin                    // HIGH_TO_LOW
                    state_d  = ST_LOW;
                    lo_cnt_d = CNT_ONE;
                end
            end
            ST_LOW: begin
                if (!sync_s) begin
                    lo_cnt_d = sat_inc(lo_cnt_q);
                end else begin                    // COMMIT
                    commit   = 1'b1;
                    state_d  = ST_HIGH;
                    hi_cnt_d = CNT_ONE;
                end
            end
            default: state_d = ST_HUNT;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_HUNT;
            hi_cnt_q <= '0;
            lo_cnt_q <= '0;
            prev_q   <= 1'b0;
        end else begin
            state_q  <= state_d;
            hi_cnt_q <= hi_cnt_d;
            lo_cnt_q <= lo_cnt_d;
            prev_q   <= sync_s;
        end
    end

    // output register: polarity flag
    always_ff @(posedge clk) begin
        if (rst)         pol_pos_q <= 1'b0;
        else if (commit) pol_pos_q <= (hi_cnt_q < lo_cnt_q);
    end

    assign pol_pos = pol_pos_q;

    // R7: no polarity before the first complete period
    a_r7_hunt_negative: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HUNT) |-> !pol_pos_q);

    // R7: flag moves only on a rising edge that closes a low phase
    a_r7_commit_only: assert property (@(posedge clk) disable iff (rst)
        !$stable(pol_pos_q) |-> $past(state_q == ST_LOW && sync_s));

    // R6: a committed flag reflects the phase comparison
    a_r6_rule: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LOW && sync_s) |=> (pol_pos_q == $past(hi_cnt_q < lo_cnt_q)));

endmodule

// File: rtl/spc_out_stage.sv
module spc_out_stage
    import spc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sync_s,
    input  logic auto_en,
    input  logic inv_sel,
    input  logic det_pos,
    output logic sync_out
);
    out_mode_e mode_q, mode_d;
    logic      out_q, out_d;

    always_comb begin
        unique case ({auto_en, inv_sel})
            2'b00:   mode_d = MODE_PASS;
            2'b01:   mode_d = MODE_INV;
            2'b10:   mode_d = MODE_NEG;
            default: mode_d = MODE_POS;
        endcase
    end

    // mode register
    always_ff @(posedge clk) begin
        if (rst) mode_q <= MODE_PASS;
        else     mode_q <= mode_d;
    end

    always_comb begin
        unique case (mode_q)
            MODE_PASS: out_d = sync_s;
            MODE_INV:  out_d = ~sync_s;
            MODE_NEG:  out_d = sync_s ^ det_pos;
            MODE_POS:  out_d = sync_s ^ ~det_pos;
            default:   out_d = sync_s;
        endcase
    end

    // output register
    always_ff @(posedge clk) begin
        if (rst) out_q <= 1'b0;
        else     out_q <= out_d;
    end

    assign sync_out = out_q;

    a_r1_pass: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_PASS) |=> (sync_out == $past(sync_s)));

    a_r2_invert: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_INV) |=> (sync_out == !$past(sync_s)));

    a_r3_negative: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_NEG) |=> (sync_out == $past(sync_s ^ det_pos)));

    a_r4_positive: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_POS) |=> (sync_out == $past(sync_s ^ !det_pos)));

endmodule

// File: rtl/sync_pol_ctrl.sv
module sync_pol_ctrl #(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic sync_in,
    input  logic auto_en,
    input  logic inv_sel,
    output logic sync_out,
    output logic pol_pos
);
    logic sync_s;
    logic det_pos;

    spc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (sync_in),
        .q   (sync_s)
    );

    spc_pol_detect #(.CNT_W(CNT_W)) u_detect (
        .clk     (clk),
        .rst     (rst),
        .sync_s  (sync_s),
        .pol_pos (det_pos)
    );

    spc_out_stage u_out (
        .clk      (clk),
        .rst      (rst),
        .sync_s   (sync_s),
        .auto_en  (auto_en),
        .inv_sel  (inv_sel),
        .det_pos  (det_pos),
        .sync_out (sync_out)
    );

    assign pol_pos = det_pos;

    // R5: outputs held low while in reset
    a_r5_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (!sync_out && !pol_pos));

endmodule

// File: tb/sync_pol_ctrl_bench.sv
`timescale 1ns/1ps
module sync_pol_ctrl_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sync_in = 1'b0;
    logic auto_en = 1'b0;
    logic inv_sel = 1'b0;
    logic sync_out;
    logic pol_pos;

    int   total = 0;
    int   failed = 0;
    logic chk_en = 1'b0;
    logic exp_pos = 1'b0;
    logic [2:0] hist = '0;

    always #2 clk = ~clk;

    sync_pol_ctrl u_sync_pol_ctrl (
        .clk      (clk),
        .rst      (rst),
        .sync_in  (sync_in),
        .auto_en  (auto_en),
        .inv_sel  (inv_sel),
        .sync_out (sync_out),
        .pol_pos  (pol_pos)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic model(input logic x, input logic a, input logic i, input logic p);
        if (!a) return x ^ i;
        return x ^ (p ^ i);
    endfunction

    function automatic string mode_tag(input logic a, input logic i);
        if (!a) return i ? "R2" : "R1";
        return i ? "R4" : "R3";
    endfunction

    task automatic step(input logic v);
        @(negedge clk);
        if (chk_en) chk(mode_tag(auto_en, inv_sel), sync_out,
                        model(hist[2], auto_en, inv_sel, exp_pos));
        hist    = {hist[1:0], v};
        sync_in = v;
    endtask

    task automatic run_pattern(input int h, input int l, input logic a, input logic i, input int np);
        auto_en = a;
        inv_sel = i;
        exp_pos = (h < l);
        chk_en  = 1'b0;
        for (int p = 0; p < 2 + np; p++) begin
            if (p == 2) chk_en = 1'b1;
            for (int k = 0; k < h; k++) step(1'b1);
            for (int k = 0; k < l; k++) step(1'b0);
        end
        chk_en = 1'b0;
        chk("R6", pol_pos, exp_pos);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failed++;
        total++;
        $display("FAIL R8 watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0017));
        // R5: reset with auto positive requested
        rst = 1'b1; auto_en = 1'b1; inv_sel = 1'b1; sync_in = 1'b0;
        repeat (3) @(negedge clk);
        chk("R5", sync_out, 1'b0);
        chk("R5", pol_pos, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        chk("R5", sync_out, 1'b0);     // computed in pass mode
        @(negedge clk);
        chk("R4", sync_out, 1'b1);     // auto positive, input low, negative assumed

        // R7: one partial period after reset commits nothing
        auto_en = 1'b0; inv_sel = 1'b0;
        repeat (5) step(1'b0);
        repeat (2) step(1'b1);
        repeat (20) step(1'b0);
        chk("R7", pol_pos, 1'b0);
        step(1'b1);
        step(1'b1);
        step(1'b1);
        chk("R7", pol_pos, 1'b0);
        step(1'b1);
        chk("R6", pol_pos, 1'b1);
        repeat (20) step(1'b0);

        // R8: three-clock latency of a single pulse in pass mode
        step(1'b1);
        step(1'b0);
        step(1'b0);
        chk("R8", sync_out, 1'b0);
        step(1'b0);
        chk("R8", sync_out, 1'b1);
        step(1'b0);
        chk("R8", sync_out, 1'b0);

        // directed corners
        run_pattern(5, 5, 1'b1, 1'b0, 3);   // tie -> negative (R6)
        run_pattern(1, 40, 1'b1, 1'b1, 2);  // narrow high pulse
        run_pattern(40, 1, 1'b1, 1'b0, 2);  // narrow low pulse
        run_pattern(3, 9, 1'b0, 1'b1, 2);
        run_pattern(9, 3, 1'b1, 1'b1, 2);

        // constrained random
        for (int n = 0; n < 30; n++) begin
            int h, l;
            logic [1:0] m;
            h = 1 + int'($urandom % 24);
            l = 1 + int'($urandom % 24);
            if (h + l < 4) l = l + 3;
            m = 2'($urandom % 4);
            run_pattern(h, l, m[1], m[0], 3);
        end

        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

endmodule